// File: doc/BRIEF.md
# Primary Data Cache Index Maintenance Unit

This block runs maintenance commands on a small primary data cache by line index instead of by address lookup. It owns the cache's per-line tag, coherence state and dirty (write-back) bit, plus the line data array and the per-doubleword check bits. A command gives a 3-bit operation code, a line index and a doubleword select. The supported operations are:

- invalidate a line, writing it back first if it is dirty;
- copy a line's tag into host-visible holding registers;
- write a line's tag from those holding registers.

A write-back leaves the block on a request/acknowledge memory port, one 64-bit doubleword per beat. Each beat carries its address, its data and eight check bits. The write-back address is rebuilt from the line's stored tag. To test error handling further down the path, the host can set an injection enable. The unit then XORs its check-bit holding register into the check bits of the selected doubleword. A fill port is the cache datapath's side of the data array. It writes line data, and the check bits for that data are computed as it is stored. A parameter picks the data-side variant, which writes back on invalidate, or the instruction-side variant, which only invalidates.

Top module: `dcache_maint`

## Requirements
- R1: A command is accepted in a cycle where `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until the command completes. `done` is a one-cycle pulse in the first cycle that `busy` is low again.
- R2: On the data-side variant, code 0 on a line whose state is not Invalid (state 0) and whose dirty bit is set writes the line back as BEATS beats, beat 0 first. Each beat's address is {stored tag, index, beat, 3'b000}, and its data is that doubleword of the line. A beat holds `mem_req`, address, data and check bits steady until `mem_ack`, and only then does the next beat start.
- R3: Code 0 on a line that is Invalid or whose dirty bit is clear makes no memory request.
- R4: After code 0 the line is Invalid (state 0), and its tag and dirty bit are unchanged.
- R5: Bit b of `mem_chk` is the XOR of data byte b (bits 8b+7..8b), which is even parity. When `inj_en` is high, the check-bit holding register is XORed into `mem_chk`, but only on the beat whose number equals the command's doubleword select.
- R6: Code 1 loads the line's tag, state, dirty bit and stored tag parity into the holding registers. The layout is `tag_lo` = {tag[23:0], state[1:0], dirty, 4'b0, parity} and `tag_hi` = tag[TAG_W-1:24], zero-extended. `ecc_q` receives the stored check bits of the selected doubleword.
- R7: Code 2 writes the line's tag, state and dirty bit from the same layout of `tag_lo`/`tag_hi`. The stored parity is the XOR of {tag, state, dirty}, and `tag_lo[0]` is ignored.
- R8: Codes 3 to 7 hold `busy` for exactly one cycle, make no memory request and leave the line unchanged.
- R9: On the instruction-side variant (DATA_SIDE=0), code 0 invalidates without any memory request, even when the line is dirty.
- R10: The host writes the holding registers through `hold_we`. Bit 0 selects `tag_lo`, bit 1 selects `tag_hi`, and bit 2 selects `ecc_q`, which takes `hold_wdata[7:0]`.
- R11: After reset, `busy`, `done`, `mem_req` and all holding registers are zero, and every line is Invalid with a zero tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_idx | input | IDX_W | Line index |
| cmd_dw | input | BEAT_W | Doubleword select |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| hold_we | input | 3 | Holding register write enables |
| hold_wdata | input | 32 | Holding register write data |
| inj_en | input | 1 | Check-bit error injection enable |
| tag_lo | output | 32 | Low tag holding register |
| tag_hi | output | 32 | High tag holding register |
| ecc_q | output | 8 | Check-bit holding register |
| fill_we | input | 1 | Data array fill strobe |
| fill_idx | input | IDX_W | Fill line index |
| fill_dw | input | BEAT_W | Fill doubleword |
| fill_data | input | 64 | Fill data |
| mem_req | output | 1 | Write-back beat request |
| mem_addr | output | TAG_W+IDX_W+BEAT_W+3 | Beat byte address |
| mem_data | output | 64 | Beat data |
| mem_chk | output | 8 | Beat check bits |
| mem_ack | input | 1 | Beat accepted |

## Verification
The hardest case to reach is a write-back whose injected corruption lands on one beat and not on the others. Reaching it needs a dirty line with a non-Invalid state, which exists only after a tag-store command. It also needs a known check-bit holding value and a doubleword select that picks a different beat on different lines. The bench fills every line and stores tags so that the eight lines cover every mix of state and dirty bit. It then sweeps code 0 over all lines. Injection is on for odd lines, the select alternates, and the acknowledge delay varies from line to line. Every beat is compared with addresses and parity computed arithmetically in the bench. A second instance with the instruction-side variant receives the same commands, and the bench checks that it never requests memory.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam logic [2:0] OPC_INVAL  = 3'd0;
  localparam logic [2:0] OPC_TAG_RD = 3'd1;
  localparam logic [2:0] OPC_TAG_WR = 3'd2;
  localparam logic [1:0] LS_INVALID = 2'd0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_RD,
    S_DRIVE,
    S_SEND
  } mnt_phase_e;
endpackage

// File: rtl/cmu_chk_gen.sv
module cmu_chk_gen #(
  parameter int BYTES = 8
) (
  input  logic [8*BYTES-1:0] data,
  output logic [BYTES-1:0]   chk
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign chk[b] = ^data[8*b +: 8];
  end
endmodule

// File: rtl/cmu_tag_store.sv
module cmu_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 28,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TAG_W-1:0] wtag,
  input  logic [1:0]       wstate,
  input  logic             wwbit,
  input  logic [IDX_W-1:0] raddr,
  output logic [TAG_W-1:0] rtag,
  output logic [1:0]       rstate,
  output logic             rwbit,
  output logic             rpar
);
  logic [TAG_W-1:0] tag_a [LINES];
  logic [1:0]       st_a  [LINES];
  logic             wb_a  [LINES];
  logic             par_a [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        tag_a[i] <= '0;
        st_a[i]  <= '0;
        wb_a[i]  <= 1'b0;
        par_a[i] <= 1'b0;
      end
    end else if (we) begin
      tag_a[waddr] <= wtag;
      st_a[waddr]  <= wstate;
      wb_a[waddr]  <= wwbit;
      par_a[waddr] <= ^{wtag, wstate, wwbit};
    end
  end

  assign rtag   = tag_a[raddr];
  assign rstate = st_a[raddr];
  assign rwbit  = wb_a[raddr];
  assign rpar   = par_a[raddr];
endmodule

// File: rtl/cmu_data_store.sv
module cmu_data_store #(
  parameter int IDX_W  = 3,
  parameter int BEAT_W = 1,
  parameter int DATA_W = 64,
  localparam int CHK_W = DATA_W / 8,
  localparam int AW    = IDX_W + BEAT_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [AW-1:0]     ck_addr,
  output logic [CHK_W-1:0]  ck_data
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic [CHK_W-1:0]  ck_a [DEPTH];

  // Plain synchronous-read memory so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    rd_data <= ram[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ck_a[i] <= '0;
    end else if (wr_en) begin
      ck_a[wr_addr] <= wr_chk;
    end
  end

  assign ck_data = ck_a[ck_addr];
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint import cmu_pkg::*; #(
  parameter int  IDX_W     = 3,
  parameter int  BEATS     = 2,
  parameter int  TAG_W     = 28,
  parameter bit  DATA_SIDE = 1'b1,
  localparam int BEAT_W    = $clog2(BEATS),
  localparam int ADDR_W    = TAG_W + IDX_W + BEAT_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [BEAT_W-1:0] cmd_dw,
  output logic              busy,
  output logic              done,
  input  logic [2:0]        hold_we,
  input  logic [31:0]       hold_wdata,
  input  logic              inj_en,
  output logic [31:0]       tag_lo,
  output logic [31:0]       tag_hi,
  output logic [7:0]        ecc_q,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [BEAT_W-1:0] fill_dw,
  input  logic [63:0]       fill_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_data,
  output logic [7:0]        mem_chk,
  input  logic              mem_ack
);
  localparam int TAG_HI_W = TAG_W - 24;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  mnt_phase_e        ph_q;
  logic              busy_q, done_q;
  logic [2:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BEAT_W-1:0] dw_q, beat_q;
  logic [31:0]       lo_q, hi_q;
  logic [7:0]        ecc_r;
  logic              mreq_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [63:0]       mdata_q;
  logic [7:0]        mchk_q;

  logic [TAG_W-1:0]  rd_tag;
  logic [1:0]        rd_state;
  logic              rd_wbit, rd_par;
  logic [63:0]       ram_q;
  logic [7:0]        ck_q, fill_chk, wb_chk;

  logic              wb_allowed, need_wb, accept, last_beat;
  logic              look_done, send_done, finish;
  logic              tw_en, is_store;
  logic [TAG_W-1:0]  tw_tag;
  logic [1:0]        tw_state;
  logic              tw_wbit;
  logic [7:0]        inj_mask;
  logic              unused_bits;

  // Variant choice: only the data-side unit writes dirty lines back.
  if (DATA_SIDE) begin : g_dside
    assign wb_allowed = 1'b1;
  end else begin : g_iside
    assign wb_allowed = 1'b0;
  end

  cmu_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst),
    .we(tw_en), .waddr(idx_q), .wtag(tw_tag), .wstate(tw_state), .wwbit(tw_wbit),
    .raddr(idx_q), .rtag(rd_tag), .rstate(rd_state), .rwbit(rd_wbit), .rpar(rd_par)
  );

  cmu_chk_gen #(.BYTES(8)) fill_gen_i (.data(fill_data), .chk(fill_chk));
  cmu_chk_gen #(.BYTES(8)) wb_gen_i   (.data(ram_q),     .chk(wb_chk));

  cmu_data_store #(.IDX_W(IDX_W), .BEAT_W(BEAT_W), .DATA_W(64)) data_i (
    .clk(clk), .rst(rst),
    .wr_en(fill_we), .wr_addr({fill_idx, fill_dw}), .wr_data(fill_data), .wr_chk(fill_chk),
    .rd_addr({idx_q, beat_q}), .rd_data(ram_q),
    .ck_addr({idx_q, dw_q}), .ck_data(ck_q)
  );

  always_comb begin
    accept    = cmd_valid && !busy_q;
    last_beat = (beat_q == LAST_BEAT);
    need_wb   = wb_allowed && (rd_state != LS_INVALID) && rd_wbit;
    look_done = (ph_q == S_LOOK) && !((op_q == OPC_INVAL) && need_wb);
    send_done = (ph_q == S_SEND) && mem_ack && last_beat;
    finish    = look_done || send_done;
    is_store  = (op_q == OPC_TAG_WR);
    tw_en     = ((ph_q == S_LOOK) && is_store) ||
                ((ph_q == S_LOOK) && (op_q == OPC_INVAL) && !need_wb) ||
                send_done;
    if (is_store) begin
      tw_tag   = {hi_q[TAG_HI_W-1:0], lo_q[31:8]};
      tw_state = lo_q[7:6];
      tw_wbit  = lo_q[5];
    end else begin
      tw_tag   = rd_tag;
      tw_state = LS_INVALID;
      tw_wbit  = rd_wbit;
    end
    inj_mask = (inj_en && (beat_q == dw_q)) ? ecc_r : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= S_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
      idx_q   <= '0;
      dw_q    <= '0;
      beat_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      ecc_r   <= '0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
      mchk_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (hold_we[0]) lo_q  <= hold_wdata;
      if (hold_we[1]) hi_q  <= hold_wdata;
      if (hold_we[2]) ecc_r <= hold_wdata[7:0];
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      unique case (ph_q)
        S_IDLE: begin
          if (accept) begin
            op_q   <= cmd_op;
            idx_q  <= cmd_idx;
            dw_q   <= cmd_dw;
            beat_q <= '0;
            busy_q <= 1'b1;
            ph_q   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (op_q == OPC_TAG_RD) begin
            lo_q  <= {rd_tag[23:0], rd_state, rd_wbit, 4'b0000, rd_par};
            hi_q  <= {{(32-TAG_HI_W){1'b0}}, rd_tag[TAG_W-1:24]};
            ecc_r <= ck_q;
          end
          ph_q <= look_done ? S_IDLE : S_DRIVE;
        end
        S_RD: ph_q <= S_DRIVE;
        S_DRIVE: begin
          mreq_q  <= 1'b1;
          maddr_q <= {rd_tag, idx_q, beat_q, 3'b000};
          mdata_q <= ram_q;
          mchk_q  <= wb_chk ^ inj_mask;
          ph_q    <= S_SEND;
        end
        S_SEND: begin
          if (mem_ack) begin
            mreq_q <= 1'b0;
            if (last_beat) begin
              ph_q <= S_IDLE;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
              ph_q   <= S_RD;
            end
          end
        end
        default: ph_q <= S_IDLE;
      endcase
    end
  end

  assign unused_bits = ^{lo_q[4:0], hi_q[31:TAG_HI_W]};

  assign busy     = busy_q;
  assign done     = done_q;
  assign tag_lo   = lo_q;
  assign tag_hi   = hi_q;
  assign ecc_q    = ecc_r;
  assign mem_req  = mreq_q;
  assign mem_addr = maddr_q;
  assign mem_data = mdata_q;
  assign mem_chk  = mchk_q;
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
  parameter int ADDR_W = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [63:0]       mem_data,
  input logic [7:0]        mem_chk
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_end_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_chk)));
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(TAG_W + IDX_W + BEAT_W + 3)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_chk(mem_chk)
);

// File: tb/dcache_maint_tb_top.sv
module dcache_maint_tb_top;
  localparam int IDX_W = 3;
  localparam int BEATS = 2;
  localparam int TAG_W = 28;
  localparam int LINES = 8;
  localparam int AW    = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [IDX_W-1:0] cmd_idx = '0;
  logic cmd_dw = 1'b0;
  logic [2:0] hold_we = '0;
  logic [31:0] hold_wdata = '0;
  logic inj_en = 1'b0;
  logic fill_we = 1'b0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic fill_dw = 1'b0;
  logic [63:0] fill_data = '0;
  logic mem_ack = 1'b0;
  logic mem_ack_j = 1'b0;

  logic busy, done, mem_req, busy_j, done_j, mem_req_j;
  logic [31:0] tag_lo, tag_hi, tag_lo_j, tag_hi_j;
  logic [7:0] ecc_q, ecc_q_j, mem_chk, mem_chk_j;
  logic [AW-1:0] mem_addr, mem_addr_j;
  logic [63:0] mem_data, mem_data_j;

  int errors = 0, checks = 0, ack_dly = 0, cap_n = 0;
  logic j_req_seen = 1'b0;
  logic [AW-1:0] cap_a [64];
  logic [63:0]   cap_d [64];
  logic [7:0]    cap_c [64];

  always #5 clk = ~clk;

  dcache_maint #(.IDX_W(IDX_W), .BEATS(BEATS), .TAG_W(TAG_W), .DATA_SIDE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_dw(cmd_dw), .busy(busy), .done(done), .hold_we(hold_we), .hold_wdata(hold_wdata),
    .inj_en(inj_en), .tag_lo(tag_lo), .tag_hi(tag_hi), .ecc_q(ecc_q), .fill_we(fill_we),
    .fill_idx(fill_idx), .fill_dw(fill_dw), .fill_data(fill_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_chk(mem_chk), .mem_ack(mem_ack));

  dcache_maint #(.IDX_W(IDX_W), .BEATS(BEATS), .TAG_W(TAG_W), .DATA_SIDE(1'b0)) dut_j (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_dw(cmd_dw), .busy(busy_j), .done(done_j), .hold_we(hold_we), .hold_wdata(hold_wdata),
    .inj_en(inj_en), .tag_lo(tag_lo_j), .tag_hi(tag_hi_j), .ecc_q(ecc_q_j), .fill_we(fill_we),
    .fill_idx(fill_idx), .fill_dw(fill_dw), .fill_data(fill_data), .mem_req(mem_req_j),
    .mem_addr(mem_addr_j), .mem_data(mem_data_j), .mem_chk(mem_chk_j), .mem_ack(mem_ack_j));

  function automatic logic [63:0] ldata(int i, int b);
    return {8'(i * 17 + 3), 8'(b * 85), 16'(16'hBEEF ^ (i * 37)), 32'(32'h0F1E2D3C + i * 1000 + b * 7)};
  endfunction
  function automatic logic [27:0] etag(int i);
    return 28'(28'h9ABC000 + i * 4919);
  endfunction
  function automatic logic [1:0] est(int i);
    return 2'(i % 4);
  endfunction
  function automatic logic ewb(int i);
    return 1'((i / 4) % 2);
  endfunction
  function automatic logic [7:0] par8(logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) begin
      p[b] = 1'b0;
      for (int k = 0; k < 8; k++) p[b] = p[b] ^ d[8 * b + k];
    end
    return p;
  endfunction
  function automatic logic [31:0] exp_lo(logic [27:0] t, logic [1:0] s, logic w);
    return {t[23:0], s, w, 4'b0000, ^{t, s, w}};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic expect_eq(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic hw(logic [2:0] we, logic [31:0] d);
    @(negedge clk);
    hold_we = we;
    hold_wdata = d;
    @(negedge clk);
    hold_we = '0;
  endtask

  task automatic run_cmd(logic [2:0] op, int idx, int dw, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_idx = IDX_W'(idx);
    cmd_dw = 1'(dw);
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_eq("R1 busy after accept", 64'(busy), 64'd1);
    cyc = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) cyc++;
    end
    expect_eq("R1 done pulse", 64'(done), 64'd1);
    @(negedge clk);
    expect_eq("R1 done single", 64'(done), 64'd0);
  endtask

  // Memory responder: acknowledges each beat after ack_dly cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        repeat (ack_dly) @(negedge clk);
        cap_a[cap_n] = mem_addr;
        cap_d[cap_n] = mem_data;
        cap_c[cap_n] = mem_chk;
        cap_n = cap_n + 1;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  always @(negedge clk) if (mem_req_j) j_req_seen <= 1'b1;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int cyc, base, nexp;
    logic [27:0] t;
    logic [7:0] pat;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    expect_eq("R11 busy", 64'(busy), 64'd0);
    expect_eq("R11 done", 64'(done), 64'd0);
    expect_eq("R11 mem_req", 64'(mem_req), 64'd0);
    expect_eq("R11 tag_lo", 64'(tag_lo), 64'd0);
    expect_eq("R11 tag_hi", 64'(tag_hi), 64'd0);
    expect_eq("R11 ecc", 64'(ecc_q), 64'd0);
    run_cmd(3'd1, 3, 0, cyc);
    expect_eq("R11 line invalid after reset", 64'(tag_lo), 64'd0);

    // Fill every doubleword of every line
    for (int i = 0; i < LINES; i++)
      for (int b = 0; b < BEATS; b++) begin
        @(negedge clk);
        fill_we = 1'b1;
        fill_idx = IDX_W'(i);
        fill_dw = 1'(b);
        fill_data = ldata(i, b);
        @(negedge clk);
        fill_we = 1'b0;
      end

    // R7 store tags with a wrong parity bit and junk in the zero field
    for (int i = 0; i < LINES; i++) begin
      t = etag(i);
      hw(3'b001, {t[23:0], est(i), ewb(i), 4'b1010, 1'b1});
      hw(3'b010, 32'(t[27:24]));
      run_cmd(3'd2, i, 0, cyc);
    end

    // R6/R7 load tags back
    for (int i = 0; i < LINES; i++) begin
      t = etag(i);
      run_cmd(3'd1, i, i % 2, cyc);
      expect_eq("R7 tag_lo stored fields and parity", 64'(tag_lo), 64'(exp_lo(t, est(i), ewb(i))));
      expect_eq("R6 tag_hi", 64'(tag_hi), 64'(t[27:24]));
      expect_eq("R6 ecc from stored check bits", 64'(ecc_q), 64'(par8(ldata(i, i % 2))));
      expect_eq("R7 second variant tag_lo", 64'(tag_lo_j), 64'(exp_lo(t, est(i), ewb(i))));
    end

    // R10 host writes of holding registers
    hw(3'b100, 32'hFFFF_FFC3);
    expect_eq("R10 ecc write", 64'(ecc_q), 64'h C3);
    hw(3'b001, 32'h1357_9BDF);
    expect_eq("R10 tag_lo write", 64'(tag_lo), 64'h1357_9BDF);
    hw(3'b010, 32'h0000_0ACE);
    expect_eq("R10 tag_hi write", 64'(tag_hi), 64'h0ACE);

    // R8 unused codes
    for (int op = 3; op < 8; op++) begin
      base = cap_n;
      run_cmd(3'(op), 6, 0, cyc);
      expect_eq("R8 one busy cycle", 64'(cyc), 64'd1);
      expect_eq("R8 no memory beat", 64'(cap_n - base), 64'd0);
    end
    run_cmd(3'd1, 6, 0, cyc);
    expect_eq("R8 line unchanged", 64'(tag_lo), 64'(exp_lo(etag(6), est(6), ewb(6))));

    // R2/R3/R5 code 0 sweep
    for (int i = 0; i < LINES; i++) begin
      t = etag(i);
      pat = 8'(8'h81 ^ (i * 8'h13));
      hw(3'b100, 32'(pat));
      inj_en = 1'(i % 2);
      ack_dly = i % 3;
      base = cap_n;
      run_cmd(3'd0, i, (i / 2) % 2, cyc);
      nexp = (est(i) != 2'd0 && ewb(i)) ? BEATS : 0;
      expect_eq("R2 R3 beat count", 64'(cap_n - base), 64'(nexp));
      for (int b = 0; b < nexp; b++) begin
        expect_eq("R2 beat address", 64'(cap_a[base + b]), 64'({t, 3'(i), 1'(b), 3'b000}));
        expect_eq("R2 beat data", cap_d[base + b], ldata(i, b));
        expect_eq("R5 beat check bits", 64'(cap_c[base + b]),
                  64'(par8(ldata(i, b)) ^ (((i % 2) == 1 && b == (i / 2) % 2) ? pat : 8'h00)));
      end
    end
    inj_en = 1'b0;

    // R4/R9 lines end invalid with tag and dirty bit kept
    for (int i = 0; i < LINES; i++) begin
      t = etag(i);
      run_cmd(3'd1, i, 0, cyc);
      expect_eq("R4 invalid, tag and dirty kept", 64'(tag_lo), 64'(exp_lo(t, 2'd0, ewb(i))));
      expect_eq("R4 tag_hi kept", 64'(tag_hi), 64'(t[27:24]));
      expect_eq("R9 variant invalidated", 64'(tag_lo_j), 64'(exp_lo(t, 2'd0, ewb(i))));
    end
    expect_eq("R9 variant never requested memory", 64'(j_req_seen), 64'd0);

    // R3 dirty but invalid line: no write-back
    base = cap_n;
    run_cmd(3'd0, 7, 0, cyc);
    expect_eq("R3 invalid dirty line no beat", 64'(cap_n - base), 64'd0);

    report();
  end
endmodule